// File: doc/BRIEF.md
# Serial Link Transmit Byte Controller

This block turns a parallel byte stream into 10-bit transmit characters, one character per byte slot. A byte slot lasts ten bit times. A bit time passes on every clock cycle in which the bit-time enable `bit_en` is high, so `bit_en` stands in for a 10x bit clock that is derived from the byte rate. At the boundary between slots the block samples its control inputs and picks what the next slot carries. The choices are a captured user byte (8B/10B coded or passed raw), a fill character when no data is offered, or one of two self-test streams.

The block also drives a read strobe for an upstream FIFO. The strobe is low for six of the ten bit times of each slot that consumes a byte, which gives a 60% low duty cycle that does not depend on the system clock. Three copies of the current character leave the block. An optical-off control forces copies A and B to all zeros while copy C keeps carrying the stream for loop-back use.

Top module: `sertx_byte_ctrl`

## Requirements
- R1: While `rst_n` is low, all three character outputs are zero and `rd_n` is high. The running disparity begins negative after reset.
- R2: A bit counter advances only on cycles where `bit_en` is high, and it wraps after 10 bit times. The character outputs change once per wrap, in the cycle after the tenth enabled edge, which is bit time 0. Character bit 9 carries line bit a and bit 0 carries line bit j; bits 9:4 form the 6-bit sub-block abcdei and bits 3:0 form fghj.
- R3: With `bist_n` high and either `en_next_n` or `en_alt_n` low at a slot boundary, the slot carries `tx_data_i[7:0]` coded as an 8B/10B data character. Bits 4:0 give the 5-bit index x and bits 7:5 give the 3-bit index y. D0.0 sent at negative disparity is 10'b1001110100.
- R4: With `bist_n` high and both enables high, the input is ignored and the slot carries K28.5. It is 10'b0011111010 at negative disparity and 10'b1100000101 at positive disparity.
- R5: The running disparity is updated after every coded character, whether it is data, fill or self-test. Every coded character has 4, 5 or 6 ones.
- R6: When `mode_raw` is high in a data slot, `tx_data_i[9:0]` is sent unchanged and the running disparity is left as it was.
- R7: With `bist_n` low and both enables high, the slot carries D10.2, which is 10'b0101010101.
- R8: With `bist_n` low and either enable low, the slot carries the next element of a 511-state loop. The state s starts at 9'h1FF, steps to {s[7:0], s[8]^s[4]}, and never becomes zero. The byte sent is s[7:0], coded as a data character.
- R9: If `bist_rst` is high at a slot boundary while `bist_n` is low, the loop restarts. A loop slot then carries the first element (byte 8'hFF, which is 10'b1010110001 at negative disparity). A toggle slot leaves the next loop slot starting from the first element.
- R10: Outside self-test, `rd_n` is low during bit times 0 to 5 of each data slot and high during bit times 6 to 9. It stays high for the whole of every fill slot.
- R11: In self-test, `rd_n` is low during bit times 0 to 5 only in the slot that carries the last loop element (state 9'h0FF). It is high in every other self-test slot.
- R12: While `opt_off` is high, `chr_a` and `chr_b` are zero in the same cycle. `chr_c` always carries the current character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One bit time passes on this cycle |
| tx_data_i | input | 10 | Byte in bits 7:0, raw character in bits 9:0 |
| en_next_n | input | 1 | Active-low data enable |
| en_alt_n | input | 1 | Second active-low data enable |
| bist_n | input | 1 | Active-low self-test enable |
| bist_rst | input | 1 | Restarts the self-test loop |
| mode_raw | input | 1 | High: data bypasses the encoder |
| opt_off | input | 1 | High: forces copies A and B to zero |
| chr_a | output | 10 | Character copy A, gated by opt_off |
| chr_b | output | 10 | Character copy B, gated by opt_off |
| chr_c | output | 10 | Character copy C, never gated |
| rd_n | output | 1 | Active-low byte-rate read strobe |

## Verification
Inputs sampled at the tenth enabled bit time show up on the character outputs and on `rd_n` one clock later, at bit time 0. Gating by `opt_off` has no register, so it acts in the same cycle. The bench model applies the sampled inputs on the same edge as the design and tracks its own bit count, so it expects each new character exactly one cycle after the wrap edge. When `bit_en` has gaps, the model predicts the `rd_n` edge that comes after bit time 5 at the right cycle. Every comparison happens one time unit after the falling clock edge, after the registers and the `opt_off` gating have settled.

// File: rtl/sertx_byte_ctrl.sv
module sertx_byte_ctrl #(
  parameter int BIT_TIMES = 10,
  parameter int RD_LOW_TIMES = 6,
  parameter logic [8:0] LOOP_SEED = 9'h1FF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic [9:0] tx_data_i,
  input  logic       en_next_n,
  input  logic       en_alt_n,
  input  logic       bist_n,
  input  logic       bist_rst,
  input  logic       mode_raw,
  input  logic       opt_off,
  output logic [9:0] chr_a,
  output logic [9:0] chr_b,
  output logic [9:0] chr_c,
  output logic       rd_n
);
  localparam int CNT_W = $clog2(BIT_TIMES);
  localparam logic [8:0] LOOP_LAST = {LOOP_SEED[0] ^ LOOP_SEED[5], LOOP_SEED[8:1]};
  localparam logic [7:0] TOGGLE_BYTE = 8'h4A;
  localparam logic [9:0] FILL_NEG = 10'b0011111010;
  localparam logic [9:0] FILL_POS = 10'b1100000101;

  function automatic logic [5:0] code6(input logic [4:0] x);
    case (x)
      5'd0:  code6 = 6'b100111;
      5'd1:  code6 = 6'b011101;
      5'd2:  code6 = 6'b101101;
      5'd3:  code6 = 6'b110001;
      5'd4:  code6 = 6'b110101;
      5'd5:  code6 = 6'b101001;
      5'd6:  code6 = 6'b011001;
      5'd7:  code6 = 6'b111000;
      5'd8:  code6 = 6'b111001;
      5'd9:  code6 = 6'b100101;
      5'd10: code6 = 6'b010101;
      5'd11: code6 = 6'b110100;
      5'd12: code6 = 6'b001101;
      5'd13: code6 = 6'b101100;
      5'd14: code6 = 6'b011100;
      5'd15: code6 = 6'b010111;
      5'd16: code6 = 6'b011011;
      5'd17: code6 = 6'b100011;
      5'd18: code6 = 6'b010011;
      5'd19: code6 = 6'b110010;
      5'd20: code6 = 6'b001011;
      5'd21: code6 = 6'b101010;
      5'd22: code6 = 6'b011010;
      5'd23: code6 = 6'b111010;
      5'd24: code6 = 6'b110011;
      5'd25: code6 = 6'b100110;
      5'd26: code6 = 6'b010110;
      5'd27: code6 = 6'b110110;
      5'd28: code6 = 6'b001110;
      5'd29: code6 = 6'b101110;
      5'd30: code6 = 6'b011110;
      default: code6 = 6'b101011;
    endcase
  endfunction

  function automatic logic [3:0] code4(input logic [2:0] y, input logic alt);
    case (y)
      3'd0: code4 = 4'b1011;
      3'd1: code4 = 4'b1001;
      3'd2: code4 = 4'b0101;
      3'd3: code4 = 4'b1100;
      3'd4: code4 = 4'b1101;
      3'd5: code4 = 4'b1010;
      3'd6: code4 = 4'b0110;
      default: code4 = alt ? 4'b0111 : 4'b1110;
    endcase
  endfunction

  function automatic logic [10:0] enc(input logic [7:0] b, input logic rd);
    logic [5:0] s6;
    logic [3:0] s4;
    logic bal6, bal4, rd1, alt;
    s6 = code6(b[4:0]);
    bal6 = ($countones(s6) == 3);
    if (rd && (!bal6 || b[4:0] == 5'd7)) s6 = ~s6;
    rd1 = rd ^ !bal6;
    alt = (b[7:5] == 3'd7) &&
          ((!rd1 && (b[4:0] == 5'd17 || b[4:0] == 5'd18 || b[4:0] == 5'd20)) ||
           (rd1 && (b[4:0] == 5'd11 || b[4:0] == 5'd13 || b[4:0] == 5'd14)));
    s4 = code4(b[7:5], alt);
    bal4 = ($countones(s4) == 2);
    if (rd1 && (!bal4 || b[7:5] == 3'd3)) s4 = ~s4;
    enc = {rd1 ^ !bal4, s6, s4};
  endfunction

  logic [CNT_W-1:0] cnt;
  logic [9:0] chr_q, nxt_chr;
  logic rd_pos, nxt_rd, slot_rd, nxt_slot_rd;
  logic [8:0] lfsr, nxt_lfsr, seq_state;
  logic tick, data_slot;

  assign tick = bit_en && (cnt == CNT_W'(BIT_TIMES - 1));
  assign data_slot = !en_next_n || !en_alt_n;
  assign seq_state = bist_rst ? LOOP_SEED : lfsr;

  always_comb begin
    nxt_chr = chr_q;
    nxt_rd = rd_pos;
    nxt_lfsr = lfsr;
    nxt_slot_rd = 1'b0;
    if (!bist_n) begin
      if (data_slot) begin
        {nxt_rd, nxt_chr} = enc(seq_state[7:0], rd_pos);
        nxt_lfsr = {seq_state[7:0], seq_state[8] ^ seq_state[4]};
        nxt_slot_rd = (seq_state == LOOP_LAST);
      end else begin
        {nxt_rd, nxt_chr} = enc(TOGGLE_BYTE, rd_pos);
        if (bist_rst) nxt_lfsr = LOOP_SEED;
      end
    end else if (data_slot) begin
      nxt_slot_rd = 1'b1;
      if (mode_raw) nxt_chr = tx_data_i;
      else {nxt_rd, nxt_chr} = enc(tx_data_i[7:0], rd_pos);
    end else begin
      nxt_chr = rd_pos ? FILL_POS : FILL_NEG;
      nxt_rd = !rd_pos;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      chr_q <= '0;
      rd_pos <= 1'b0;
      slot_rd <= 1'b0;
      lfsr <= LOOP_SEED;
    end else if (bit_en) begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick) begin
        chr_q <= nxt_chr;
        rd_pos <= nxt_rd;
        slot_rd <= nxt_slot_rd;
        lfsr <= nxt_lfsr;
      end
    end
  end

  assign rd_n = !(slot_rd && (cnt < CNT_W'(RD_LOW_TIMES)));
  assign chr_c = chr_q;
  assign chr_a = opt_off ? '0 : chr_q;
  assign chr_b = opt_off ? '0 : chr_q;
endmodule

// File: rtl/sertx_byte_ctrl_chk.sv
module sertx_byte_ctrl_chk #(
  parameter int CNT_W = 4,
  parameter int RD_LOW_TIMES = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_next_n,
  input logic             en_alt_n,
  input logic             bist_n,
  input logic             mode_raw,
  input logic             opt_off,
  input logic [9:0]       chr_a,
  input logic [9:0]       chr_b,
  input logic [9:0]       chr_c,
  input logic             rd_n,
  input logic [CNT_W-1:0] cnt,
  input logic             tick,
  input logic             rd_pos,
  input logic [8:0]       lfsr
);
  logic raw_data;
  assign raw_data = bist_n && (!en_next_n || !en_alt_n) && mode_raw;

  assert_char_at_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chr_c) |-> $past(tick));

  assert_coded_weight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick && !raw_data) |-> ($countones(chr_c) >= 4 && $countones(chr_c) <= 6));

  assert_raw_keeps_disparity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && raw_data) |=> $stable(rd_pos));

  assert_loop_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 9'd0);

  assert_strobe_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> cnt == '0);

  assert_strobe_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> cnt == CNT_W'(RD_LOW_TIMES));

  assert_copies_follow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !opt_off |-> (chr_a == chr_c && chr_b == chr_c));
endmodule

bind sertx_byte_ctrl sertx_byte_ctrl_chk #(.CNT_W(CNT_W), .RD_LOW_TIMES(RD_LOW_TIMES)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_next_n(en_next_n), .en_alt_n(en_alt_n),
  .bist_n(bist_n), .mode_raw(mode_raw), .opt_off(opt_off),
  .chr_a(chr_a), .chr_b(chr_b), .chr_c(chr_c), .rd_n(rd_n),
  .cnt(cnt), .tick(tick), .rd_pos(rd_pos), .lfsr(lfsr)
);

// File: tb/sertx_byte_ctrl_bench.sv
`timescale 1ns/1ps
module sertx_byte_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b1;
  logic [9:0] tx_data_i = '0;
  logic en_next_n = 1'b1, en_alt_n = 1'b1, bist_n = 1'b1, bist_rst = 1'b0;
  logic mode_raw = 1'b0, opt_off = 1'b0;
  logic [9:0] chr_a, chr_b, chr_c;
  logic rd_n;

  always #4 clk = ~clk;

  sertx_byte_ctrl u_sertx_byte_ctrl (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_data_i(tx_data_i),
    .en_next_n(en_next_n), .en_alt_n(en_alt_n), .bist_n(bist_n), .bist_rst(bist_rst),
    .mode_raw(mode_raw), .opt_off(opt_off),
    .chr_a(chr_a), .chr_b(chr_b), .chr_c(chr_c), .rd_n(rd_n)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit gaps = 1'b0;

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void ref_enc(input logic [7:0] b, inout bit rd, output logic [9:0] c);
    logic [5:0] p;
    logic [3:0] q;
    int x, y;
    x = int'(b[4:0]);
    y = int'(b[7:5]);
    case (x)
      0: p = 6'b100111;  1: p = 6'b011101;  2: p = 6'b101101;  3: p = 6'b110001;
      4: p = 6'b110101;  5: p = 6'b101001;  6: p = 6'b011001;  7: p = 6'b111000;
      8: p = 6'b111001;  9: p = 6'b100101;  10: p = 6'b010101; 11: p = 6'b110100;
      12: p = 6'b001101; 13: p = 6'b101100; 14: p = 6'b011100; 15: p = 6'b010111;
      16: p = 6'b011011; 17: p = 6'b100011; 18: p = 6'b010011; 19: p = 6'b110010;
      20: p = 6'b001011; 21: p = 6'b101010; 22: p = 6'b011010; 23: p = 6'b111010;
      24: p = 6'b110011; 25: p = 6'b100110; 26: p = 6'b010110; 27: p = 6'b110110;
      28: p = 6'b001110; 29: p = 6'b101110; 30: p = 6'b011110; default: p = 6'b101011;
    endcase
    if (rd && ($countones(p) != 3 || p == 6'b111000)) p = ~p;
    if ($countones(p) != 3) rd = ~rd;
    case (y)
      0: q = 4'b1011; 1: q = 4'b1001; 2: q = 4'b0101; 3: q = 4'b1100;
      4: q = 4'b1101; 5: q = 4'b1010; 6: q = 4'b0110;
      default: q = ((!rd && (x == 17 || x == 18 || x == 20)) ||
                    (rd && (x == 11 || x == 13 || x == 14))) ? 4'b0111 : 4'b1110;
    endcase
    if (rd && ($countones(q) != 2 || q == 4'b1100)) q = ~q;
    if ($countones(q) != 2) rd = ~rd;
    c = {p, q};
  endfunction

  int m_cnt = 0;
  int slots = 0;
  bit m_rd = 1'b0;
  bit m_low = 1'b0;
  logic [9:0] m_chr = '0;
  logic [8:0] m_seq = 9'h1FF;
  string m_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_rd = 1'b0; m_low = 1'b0; m_chr = '0; m_seq = 9'h1FF; m_tag = "R1";
    end else if (bit_en) begin
      if (m_cnt == 9) begin
        logic [8:0] s;
        m_cnt = 0;
        slots++;
        m_low = 1'b0;
        if (!bist_n) begin
          if (!en_next_n || !en_alt_n) begin
            s = bist_rst ? 9'h1FF : m_seq;
            ref_enc(s[7:0], m_rd, m_chr);
            m_low = (s == 9'h0FF);
            m_seq = {s[7:0], s[8] ^ s[4]};
            m_tag = bist_rst ? "R9" : "R8/R11";
          end else begin
            ref_enc(8'h4A, m_rd, m_chr);
            if (bist_rst) m_seq = 9'h1FF;
            m_tag = "R7/R11";
          end
        end else if (!en_next_n || !en_alt_n) begin
          m_low = 1'b1;
          if (mode_raw) begin
            m_chr = tx_data_i;
            m_tag = "R6/R10";
          end else begin
            ref_enc(tx_data_i[7:0], m_rd, m_chr);
            m_tag = "R3/R5/R10";
          end
        end else begin
          m_chr = m_rd ? 10'b1100000101 : 10'b0011111010;
          m_rd = ~m_rd;
          m_tag = "R4/R5/R10";
        end
      end else begin
        m_cnt++;
      end
    end
  end

  always begin
    @(negedge clk);
    #1;
    if (rst_n && !done) begin
      check({m_tag, " chr_c R2"}, chr_c, m_chr);
      check({m_tag, " chr_a R12"}, chr_a, opt_off ? 10'd0 : m_chr);
      check({m_tag, " chr_b R12"}, chr_b, opt_off ? 10'd0 : m_chr);
      check({m_tag, " rd_n"}, {9'd0, rd_n}, {9'd0, !(m_low && m_cnt < 6)});
    end
  end

  always @(negedge clk) bit_en <= gaps ? ($urandom_range(0, 3) != 0) : 1'b1;

  task automatic run_slot(input bit nn, input bit na, input bit bn, input bit br,
                          input bit mr, input logic [9:0] d);
    int start;
    en_next_n = nn; en_alt_n = na; bist_n = bn; bist_rst = br; mode_raw = mr; tx_data_i = d;
    start = slots;
    while (slots == start) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int lows;
    repeat (4) @(negedge clk);
    #1;
    check("R1 reset chr_c", chr_c, 10'd0);
    check("R1 reset chr_a", chr_a, 10'd0);
    check("R1 reset rd_n", {9'd0, rd_n}, 10'd1);
    @(negedge clk);
    rst_n = 1'b1;

    run_slot(1, 1, 1, 0, 0, 10'h155);
    check("R1/R4 fill at negative disparity", chr_c, 10'b0011111010);
    run_slot(1, 1, 1, 0, 0, 10'h0AA);
    check("R4/R5 fill at positive disparity", chr_c, 10'b1100000101);
    run_slot(0, 1, 1, 0, 0, 10'h000);
    check("R3 D0.0 negative disparity", chr_c, 10'b1001110100);
    check("R10 rd_n low at bit time 0", {9'd0, rd_n}, 10'd0);
    run_slot(1, 0, 1, 0, 1, 10'h3FF);
    check("R6 raw pattern passed", chr_c, 10'h3FF);
    run_slot(1, 1, 1, 0, 0, 10'h000);
    check("R6 disparity kept over raw slot", chr_c, 10'b0011111010);
    check("R10 rd_n high in fill slot", {9'd0, rd_n}, 10'd1);
    run_slot(1, 1, 1, 0, 0, 10'h000);
    run_slot(1, 1, 0, 0, 0, 10'h000);
    check("R7 toggle pattern", chr_c, 10'b0101010101);
    run_slot(0, 1, 0, 1, 0, 10'h000);
    check("R9 loop restarts at first element", chr_c, 10'b1010110001);

    lows = 0;
    for (int i = 1; i < 1022; i++) begin
      run_slot(0, 1, 0, 0, 0, 10'h000);
      if (!rd_n) lows++;
    end
    check("R11 one strobe per 511-slot loop", 10'(lows), 10'd2);

    @(negedge clk);
    opt_off = 1'b1;
    @(negedge clk);
    #2;
    check("R12 chr_a forced zero", chr_a, 10'd0);
    check("R12 chr_c still carries character", chr_c, m_chr);
    @(negedge clk);
    opt_off = 1'b0;

    gaps = 1'b1;
    for (int i = 0; i < 400; i++) begin
      int kind;
      kind = $urandom_range(0, 9);
      if (i % 37 == 5) begin
        @(negedge clk);
        opt_off = ~opt_off;
      end
      if (kind < 2) run_slot(1, 1, 1, 0, 0, 10'($urandom));
      else if (kind < 4) run_slot(1, 0, 1, 0, 1, 10'($urandom));
      else if (kind < 8) run_slot(0, $urandom_range(0, 1) == 1, 1, 0, 0, 10'($urandom));
      else run_slot($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 0,
                    $urandom_range(0, 7) == 0, 0, 10'($urandom));
    end
    gaps = 1'b0;
    finish_run();
  end
endmodule